// File: doc/BRIEF.md
# Chained Dual-Edge Input Capture

This block times one external signal with a pair of chained capture channels. The signal passes through a two-stage synchronizer. It can then pass through a digital glitch filter. An edge detector runs on the result. The first channel stores the value of a free-running counter, which is supplied from outside, on its chosen edge. The second channel is armed only once the first has captured. When armed, it stores the counter on its own chosen edge. The difference between the two stored values is the measurement. If both channels select the same edge, the difference is a period. If they select different edges, it is a pulse width.

Each channel has a sticky flag. Each channel also has an interrupt output, gated by that channel's enable. Software reads the two captured values and the flags over a small register port, and clears the flags by writing 1 to them. The first capture register must be read before the second. Reading the first register freezes a copy of the second, so the two values read always belong together.

A mode input selects one-shot or continuous measurement.

Top module: `dual_edge_capture`

## Requirements
- R1: With the filter off, a level change on `sig_in` that is first sampled at clock edge k sets the matching flag at edge k+3. The stored count is the `cnt_in` value at edge k+3.
- R2: Edge-select codes for `edge_a` and `edge_b` are: 00 = no capture, 01 = rising, 10 = falling, 11 = either edge. With code 00 a channel never captures.
- R3: A selected edge of the first channel, when permitted, stores `cnt_in` into capture A (address 0) and sets flag A. `irq_a` is high exactly while flag A is set and `ien_a` is 1.
- R4: The second channel captures only while it is armed and flag A is set. It is armed by a first-channel capture. A second capture stores `cnt_in` into capture B, sets flag B, and disarms the channel. `irq_b` is high exactly while flag B is set and `ien_b` is 1.
- R5: In one-shot mode (`cont_mode`=0), after the second capture neither channel captures again until both flags are clear.
- R6: In continuous mode (`cont_mode`=1), the first channel captures on its next edge after every second capture, whatever the flags are. Each capture overwrites its register.
- R7: A read of address 0 returns capture A and copies capture B into a shadow register on that clock edge. Address 1 always returns the shadow, so a capture between the two reads does not change the value returned.
- R8: Address 2 reads flag A in bit 0 and flag B in bit 1. A write to address 2 clears each flag whose `bus_wdata` bit is 1. A capture in the same cycle wins over the clear. Clearing flag A also disarms the second channel.
- R9: With `filt_en`=1 and `filt_len`=L, a new synchronized level passes only after L+1 consecutive samples. Shorter pulses cause no capture, and captures are delayed by L cycles.
- R10: The difference between capture B and capture A equals the period (same edge codes) or the pulse width (opposite edge codes) of `sig_in`, in counter ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Asynchronous signal under measurement |
| cnt_in | input | CW | Free-running timer count |
| edge_a | input | 2 | Edge select, first channel |
| edge_b | input | 2 | Edge select, second channel |
| cont_mode | input | 1 | 1 = continuous, 0 = one-shot |
| filt_en | input | 1 | Glitch filter enable |
| filt_len | input | FW | Filter hold length minus one |
| ien_a | input | 1 | Interrupt enable, first channel |
| ien_b | input | 1 | Interrupt enable, second channel |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address (0 cap A, 1 cap B shadow, 2 flags) |
| bus_wdata | input | 2 | Write data for flag clear |
| rd_data | output | CW | Read data, combinational from address |
| irq_a | output | 1 | First channel interrupt |
| irq_b | output | 1 | Second channel interrupt |

## Verification
A signal change reaches a flag and a capture register three edges after it is first sampled. Each enabled filter tap adds one edge. The bench checks the flag one edge early and again on the due edge. Read data is combinational from the address, so it is checked in the same cycle as the strobe. The shadow copy is due one edge after the read of address 0. A behavioural model advances on every rising edge and is compared on every falling edge. Stimulus changes 2 ns after the rising edge, so samples never fall on an active edge.

// File: rtl/dual_edge_capture.sv
module dual_edge_capture #(
  parameter int CW = 16,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sig_in,
  input  logic [CW-1:0] cnt_in,
  input  logic [1:0]    edge_a,
  input  logic [1:0]    edge_b,
  input  logic          cont_mode,
  input  logic          filt_en,
  input  logic [FW-1:0] filt_len,
  input  logic          ien_a,
  input  logic          ien_b,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [1:0]    bus_wdata,
  output logic [CW-1:0] rd_data,
  output logic          irq_a,
  output logic          irq_b
);

  logic          s1, s2, lvl, lvl_d;
  logic [FW-1:0] fcnt;
  logic [CW-1:0] cap_a, cap_b, shadow;
  logic          flag_a, flag_b, armed;

  function automatic logic hit(input logic [1:0] sel, input logic prev, input logic cur);
    case (sel)
      2'b01:   return !prev && cur;
      2'b10:   return prev && !cur;
      2'b11:   return prev ^ cur;
      default: return 1'b0;
    endcase
  endfunction

  wire [FW-1:0] eff_len = filt_en ? filt_len : '0;
  wire ev_a   = hit(edge_a, lvl_d, lvl);
  wire ev_b   = hit(edge_b, lvl_d, lvl);
  wire take_a = ev_a && !armed && (cont_mode || (!flag_a && !flag_b));
  wire take_b = ev_b && armed && flag_a;
  wire wr_flg = bus_wr && bus_addr == 2'd2;
  wire clr_a  = wr_flg && bus_wdata[0];
  wire clr_b  = wr_flg && bus_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; lvl <= 1'b0; lvl_d <= 1'b0;
      fcnt <= '0; cap_a <= '0; cap_b <= '0; shadow <= '0;
      flag_a <= 1'b0; flag_b <= 1'b0; armed <= 1'b0;
    end else begin
      s1    <= sig_in;
      s2    <= s1;
      lvl_d <= lvl;
      if (s2 == lvl) fcnt <= '0;
      else if (fcnt >= eff_len) begin
        lvl  <= s2;
        fcnt <= '0;
      end else fcnt <= fcnt + 1'b1;
      if (bus_rd && bus_addr == 2'd0) shadow <= cap_b;
      if (take_a) cap_a <= cnt_in;
      if (take_b) cap_b <= cnt_in;
      flag_a <= take_a || (flag_a && !clr_a);
      flag_b <= take_b || (flag_b && !clr_b);
      armed  <= take_a || (armed && !take_b && !clr_a);
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    rd_data = cap_a;
      2'd1:    rd_data = shadow;
      2'd2:    rd_data = {{(CW-2){1'b0}}, flag_b, flag_a};
      default: rd_data = '0;
    endcase
  end

  assign irq_a = flag_a && ien_a;
  assign irq_b = flag_b && ien_b;

endmodule

// File: rtl/dual_edge_capture_chk.sv
module dual_edge_capture_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt_in,
  input logic [1:0]    edge_a,
  input logic          cont_mode,
  input logic          bus_rd,
  input logic [1:0]    bus_addr,
  input logic          flag_a,
  input logic          flag_b,
  input logic [CW-1:0] cap_a,
  input logic [CW-1:0] cap_b,
  input logic [CW-1:0] shadow
);

  a_r3_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> cap_a == $past(cnt_in));

  a_r4_b_after_a: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_b) |-> $past(flag_a));

  a_r5_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_mode && flag_a && flag_b) |=> ($stable(cap_a) && $stable(cap_b)));

  a_r7_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0) |=> shadow == $past(cap_b));

  a_r2_edge_off: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_a == 2'b00 && !flag_a) |=> !flag_a);

endmodule

bind dual_edge_capture dual_edge_capture_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .edge_a(edge_a),
  .cont_mode(cont_mode), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .flag_a(flag_a), .flag_b(flag_b), .cap_a(cap_a), .cap_b(cap_b),
  .shadow(shadow)
);

// File: tb/sim_dual_edge_capture.sv
`timescale 1ns/1ps
module sim_dual_edge_capture;
  logic        clk = 0, rst_n = 0, sig_in = 0;
  logic [15:0] cnt = 0;
  logic [1:0]  edge_a = 0, edge_b = 0, bus_addr = 0, bus_wdata = 0;
  logic        cont_mode = 0, filt_en = 0, ien_a = 0, ien_b = 0, bus_rd = 0, bus_wr = 0;
  logic [3:0]  filt_len = 0;
  logic [15:0] rd_data;
  logic        irq_a, irq_b;
  int checks = 0, errors = 0;
  string phase = "R3";

  always #2.5 clk = ~clk;
  always @(posedge clk) #1 cnt = cnt + 16'd1;

  dual_edge_capture u0 (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .cnt_in(cnt), .edge_a(edge_a),
    .edge_b(edge_b), .cont_mode(cont_mode), .filt_en(filt_en), .filt_len(filt_len),
    .ien_a(ien_a), .ien_b(ien_b), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .irq_a(irq_a), .irq_b(irq_b));

  // behavioural reference
  bit q[$];
  bit m_f, m_fd, m_fa, m_fb, m_wt;
  int m_run;
  logic [15:0] m_ca, m_cb, m_sh;

  function automatic bit seen(input logic [1:0] sel, input bit was, input bit now);
    if (was == now) return 0;
    if (sel == 2'b11) return 1;
    return (sel == 2'b01) ? now : (sel == 2'b10) ? was : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q = {0, 0}; m_f = 0; m_fd = 0; m_run = 0; m_fa = 0; m_fb = 0; m_wt = 0;
      m_ca = 0; m_cb = 0; m_sh = 0;
    end else begin
      bit s2, ta, tb, ca, cb;
      int lim;
      s2 = q.pop_front();
      q.push_back(sig_in);
      ta = seen(edge_a, m_fd, m_f) && !m_wt && (cont_mode || (!m_fa && !m_fb));
      tb = seen(edge_b, m_fd, m_f) && m_wt && m_fa;
      ca = bus_wr && bus_addr == 2 && bus_wdata[0];
      cb = bus_wr && bus_addr == 2 && bus_wdata[1];
      m_fd = m_f;
      lim = filt_en ? int'(filt_len) : 0;
      if (s2 != m_f) begin
        m_run++;
        if (m_run > lim) begin m_f = s2; m_run = 0; end
      end else m_run = 0;
      if (bus_rd && bus_addr == 0) m_sh = m_cb;
      if (ta) m_ca = cnt;
      if (tb) m_cb = cnt;
      if (ca) begin m_fa = 0; m_wt = 0; end
      if (cb) m_fb = 0;
      if (ta) begin m_fa = 1; m_wt = 1; end
      if (tb) begin m_fb = 1; m_wt = 0; end
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic [15:0] e;
    e = (bus_addr == 0) ? m_ca : (bus_addr == 1) ? m_sh :
        (bus_addr == 2) ? {14'd0, m_fb, m_fa} : 16'd0;
    checks++;
    if (rd_data !== e || irq_a !== (m_fa & ien_a) || irq_b !== (m_fb & ien_b)) begin
      errors++;
      $display("FAIL %s model rd=%h/%h irq=%b%b/%b%b", phase, rd_data, e,
               irq_a, irq_b, m_fa & ien_a, m_fb & ien_b);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_rd = 1; bus_addr = a; #1; v = rd_data; tick(1); bus_rd = 0;
  endtask

  task automatic clr(input logic [1:0] m);
    bus_wr = 1; bus_addr = 2; bus_wdata = m; tick(1); bus_wr = 0; bus_wdata = 0;
  endtask

  logic [15:0] v, c0, c1, c2, b4;

  initial begin
    tick(3); rst_n = 1; tick(1);
    rd(0, v); chk("R3 reset capA", v, 0);
    rd(2, v); chk("R8 reset flags", v, 0);
    chk("R3 reset irq", {irq_a, irq_b}, 0);

    // one-shot pulse width
    phase = "R4"; edge_a = 2'b01; edge_b = 2'b10; ien_a = 1; ien_b = 1;
    sig_in = 1; c0 = cnt;
    tick(3); chk("R1 flag not early", irq_a, 0);
    tick(1); chk("R1 flag due", irq_a, 1);
    tick(6); sig_in = 0; c1 = cnt; tick(6);
    chk("R4 irq_b", irq_b, 1);
    rd(0, v); chk("R3 capA", v, c0 + 16'd3);
    rd(1, v); chk("R4 capB", v, c1 + 16'd3);
    chk("R10 width", v - (c0 + 16'd3), 10);
    rd(2, v); chk("R8 flags read", v, 3);
    ien_b = 0; #1; chk("R4 irq_b gated", irq_b, 0); ien_b = 1;

    phase = "R5"; sig_in = 1; tick(5); sig_in = 0; tick(6);
    rd(0, v); chk("R5 capA held", v, c0 + 16'd3);
    rd(1, v); chk("R5 capB held", v, c1 + 16'd3);

    phase = "R8"; clr(3); tick(1);
    rd(2, v); chk("R8 cleared", v, 0);
    chk("R8 irq low", {irq_a, irq_b}, 0);

    phase = "R2"; edge_a = 2'b00; sig_in = 1; tick(5); sig_in = 0; tick(6);
    rd(2, v); chk("R2 disabled no flag", v, 0);

    // continuous period
    phase = "R6"; cont_mode = 1; edge_a = 2'b01; edge_b = 2'b01;
    sig_in = 1; tick(3); sig_in = 0; tick(4);
    sig_in = 1; tick(3); sig_in = 0; tick(6);
    sig_in = 1; c0 = cnt; tick(3); sig_in = 0; tick(6);
    sig_in = 1; c1 = cnt; tick(3); sig_in = 0; tick(6);
    rd(0, v); chk("R6 capA overwritten", v, c0 + 16'd3);
    rd(1, v); chk("R10 period", v - (c0 + 16'd3), 9);
    b4 = c1 + 16'd3;

    phase = "R7"; sig_in = 1; c2 = cnt; tick(3); sig_in = 0; tick(6);
    rd(0, v); chk("R7 capA", v, c2 + 16'd3);
    sig_in = 1; tick(3); sig_in = 0; tick(6);
    rd(1, v); chk("R7 shadow coherent", v, b4);

    // filter
    phase = "R9"; cont_mode = 0; edge_b = 2'b10; filt_en = 1; filt_len = 3;
    clr(3); tick(2);
    sig_in = 1; tick(2); sig_in = 0; tick(10);
    rd(2, v); chk("R9 glitch rejected", v, 0);
    sig_in = 1; c0 = cnt; tick(12); sig_in = 0; c1 = cnt; tick(12);
    rd(0, v); chk("R9 capA delayed", v, c0 + 16'd6);
    rd(1, v); chk("R9 capB delayed", v, c1 + 16'd6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule